// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a simple 32-bit in-order core and decides where the next fetch goes. Each cycle it looks at the current instruction word and the two register operands read for it. From these it computes the following PC: the plain sequential step, a taken or untaken equality branch, an absolute jump, a jump that also saves a return address, or a jump to an address held in a register.

The next-PC choice is purely combinational. It is wrapped by a single PC register with synchronous reset. A stall input freezes that register for as long as the pipeline cannot accept a new instruction. A link-write request with its value lets the register file save the return address into register 31. A flag marks register jumps whose target is not word aligned.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x00000000 on that edge.
- R2: While `stall` is high, `pc` keeps its value across the edge and `link_we` stays low.
- R3: Any instruction that is not one of the control opcodes in R4 to R8 gives `pc_next` = `pc` + 4. This includes opcode 0x00 with a function field other than 0x08.
- R4: Opcode 0x04 (bits 31:26) with `rs_val` equal to `rt_val` gives `pc_next` = `pc` + 4 + (bits 15:0 sign-extended, shifted left by 2). With unequal operands it gives `pc` + 4.
- R5: Opcode 0x05 takes the branch of R4 when `rs_val` differs from `rt_val`, and gives `pc` + 4 when they are equal.
- R6: Opcode 0x02 gives `pc_next` = {bits 31:28 of `pc` + 4, instruction bits 25:0, 2'b00}.
- R7: Opcode 0x03 gives the same target as R6. Without stall it also drives `link_we` high with `link_data` = `pc` + 4. `link_we` is low for every other opcode.
- R8: Opcode 0x00 with function field 0x08 (bits 5:0) gives `pc_next` = `rs_val` with its two low bits forced to zero.
- R9: `jr_misalign` is high exactly when the R8 instruction is present and `rs_val[1:0]` is not zero.
- R10: Without stall or reset, `pc` takes the value of `pc_next` at each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC and suppresses the link write |
| instr | input | 32 | Instruction at the current PC |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Computed next program counter |
| link_we | output | 1 | Request to write the return address to register 31 |
| link_data | output | 32 | Return address (PC + 4) |
| jr_misalign | output | 1 | Register jump target not word aligned |

## Verification
The two functions that meet in one cycle are stall and the control transfer. A jump-and-link or a taken branch presented while `stall` is high must still show its target on `pc_next`. In the same cycle it must leave `pc` unchanged and keep the link write off. The bench provokes this by holding `stall` during such an instruction at a known PC. It judges the combinational outputs before the edge and the register after it, then releases the stall and confirms that the held instruction now takes effect. A misaligned register jump under stall is judged in the same way.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] pc_next,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic        jr_misalign
);

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JMP     = 6'h02;
  localparam logic [5:0] OP_JMPLNK  = 6'h03;
  localparam logic [5:0] OP_BREQ    = 6'h04;
  localparam logic [5:0] OP_BRNE    = 6'h05;
  localparam logic [5:0] FN_JREG    = 6'h08;

  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [31:0] pc_seq;
  logic [31:0] br_off;
  logic [31:0] br_tgt;
  logic [31:0] jmp_tgt;
  logic [31:0] reg_tgt;
  logic        ops_eq;
  logic        is_jreg;
  logic        br_take;

  assign opc     = instr[31:26];
  assign fn      = instr[5:0];
  assign pc_seq  = pc + 32'd4;
  assign br_off  = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign br_tgt  = pc_seq + br_off;
  assign jmp_tgt = {pc_seq[31:28], instr[25:0], 2'b00};
  assign reg_tgt = {rs_val[31:2], 2'b00};
  assign ops_eq  = (rs_val == rt_val);
  assign is_jreg = (opc == OP_SPECIAL) && (fn == FN_JREG);
  assign br_take = ((opc == OP_BREQ) && ops_eq) || ((opc == OP_BRNE) && !ops_eq);

  always_comb begin
    if (is_jreg)
      pc_next = reg_tgt;
    else if ((opc == OP_JMP) || (opc == OP_JMPLNK))
      pc_next = jmp_tgt;
    else if (br_take)
      pc_next = br_tgt;
    else
      pc_next = pc_seq;
  end

  assign link_we     = (opc == OP_JMPLNK) && !stall;
  assign link_data   = pc_seq;
  assign jr_misalign = is_jreg && (rs_val[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (rst)
      pc <= RESET_PC;
    else if (!stall)
      pc <= pc_next;
  end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] pc,
  input logic [31:0] pc_next,
  input logic        link_we,
  input logic [31:0] link_data,
  input logic        jr_misalign
);

  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> pc == 32'h0000_0000);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc));

  p_stall_nolink_r2: assert property (@(posedge clk) disable iff (rst)
    stall |-> !link_we);

  p_link_ret_r7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_data == pc + 32'd4) && (instr[31:26] == 6'h03));

  p_misalign_src_r9: assert property (@(posedge clk) disable iff (rst)
    jr_misalign |-> (rs_val[1:0] != 2'b00) && (pc_next[1:0] == 2'b00));

  p_follow_next_r10: assert property (@(posedge clk) disable iff (rst)
    !stall |=> pc == $past(pc_next));

  p_pc_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

bind npc_unit npc_unit_chk chk_i (
  .clk(clk), .rst(rst), .stall(stall), .instr(instr), .rs_val(rs_val),
  .pc(pc), .pc_next(pc_next), .link_we(link_we), .link_data(link_data),
  .jr_misalign(jr_misalign)
);

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] pc, pc_next, link_data;
  logic        link_we, jr_misalign;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr), .rs_val(rs_val),
    .rt_val(rt_val), .pc(pc), .pc_next(pc_next), .link_we(link_we),
    .link_data(link_data), .jr_misalign(jr_misalign)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] jr_word();
    return {6'h00, 5'd1, 15'd0, 6'h08};
  endfunction

  task automatic load_pc(input logic [31:0] v);
    stall = 1'b0; instr = jr_word(); rs_val = v; rt_val = 32'h0;
    @(posedge clk); #1;
  endtask

  task automatic step_chk(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp, input string tag);
    instr = i; rs_val = a; rt_val = b; #2;
    chk(pc_next == exp, tag, pc_next, exp);
    @(posedge clk); #1;
    chk(pc == exp, "R10 pc follows", pc, exp);
  endtask

  initial begin
    logic [31:0] pcs [6];
    logic [15:0] imms [6];
    logic [25:0] adrs [4];
    pcs  = '{32'h0000_0000, 32'h0000_1000, 32'h0FFF_FFFC, 32'h8000_0010, 32'hFFFF_FFF8, 32'h1234_5678};
    imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    adrs = '{26'h0000000, 26'h3FFFFFF, 26'h1555555, 26'h0000040};

    repeat (2) @(posedge clk); #1;
    chk(pc == 32'h0, "R1 reset pc", pc, 32'h0);
    rst = 1'b0;

    foreach (pcs[p]) begin
      logic [31:0] base, p4;
      base = {pcs[p][31:2], 2'b00};
      p4 = base + 32'd4;
      load_pc(base);
      chk(pc == base, "R8 jr load", pc, base);
      step_chk({6'h08, 5'd2, 5'd3, 16'h0010}, 32'h5, 32'h5, base + 32'd4, "R3 sequential addi");
      load_pc(base);
      step_chk({6'h00, 5'd2, 5'd3, 5'd4, 5'd0, 6'h20}, 32'h5, 32'h6, base + 32'd4, "R3 sequential add funct");
      foreach (imms[k]) begin
        logic [31:0] tg;
        tg = p4 + {{14{imms[k][15]}}, imms[k], 2'b00};
        load_pc(base);
        step_chk({6'h04, 5'd1, 5'd2, imms[k]}, 32'hA5A5_0001, 32'hA5A5_0001, tg, "R4 beq taken");
        load_pc(base);
        step_chk({6'h04, 5'd1, 5'd2, imms[k]}, 32'hA5A5_0001, 32'hA5A5_0003, p4, "R4 beq not taken");
        load_pc(base);
        step_chk({6'h05, 5'd1, 5'd2, imms[k]}, 32'h0, 32'h8000_0000, tg, "R5 bne taken");
        load_pc(base);
        step_chk({6'h05, 5'd1, 5'd2, imms[k]}, 32'h77, 32'h77, p4, "R5 bne not taken");
      end
      foreach (adrs[k]) begin
        logic [31:0] jt;
        jt = {p4[31:28], adrs[k], 2'b00};
        load_pc(base);
        instr = {6'h02, adrs[k]}; #2;
        chk(!link_we, "R7 j no link", {31'h0, link_we}, 32'h0);
        step_chk({6'h02, adrs[k]}, 32'h0, 32'h0, jt, "R6 j target");
        load_pc(base);
        instr = {6'h03, adrs[k]}; #2;
        chk(link_we, "R7 jal link_we", {31'h0, link_we}, 32'h1);
        chk(link_data == p4, "R7 jal link_data", link_data, p4);
        step_chk({6'h03, adrs[k]}, 32'h0, 32'h0, jt, "R7 jal target");
      end
    end

    load_pc(32'h0000_2000);
    instr = jr_word(); rs_val = 32'h0000_4003; #2;
    chk(jr_misalign, "R9 misaligned flag", {31'h0, jr_misalign}, 32'h1);
    chk(pc_next == 32'h0000_4000, "R8 low bits cleared", pc_next, 32'h0000_4000);
    rs_val = 32'h0000_4004; #2;
    chk(!jr_misalign, "R9 aligned no flag", {31'h0, jr_misalign}, 32'h0);
    instr = {6'h04, 5'd1, 5'd2, 16'h0001}; rs_val = 32'h3; #2;
    chk(!jr_misalign, "R9 non-jr no flag", {31'h0, jr_misalign}, 32'h0);

    load_pc(32'h0000_3000);
    stall = 1'b1; instr = {6'h03, 26'h0000100}; #2;
    chk(!link_we, "R2 stall blocks link", {31'h0, link_we}, 32'h0);
    chk(pc_next == 32'h0000_0400, "R6 target under stall", pc_next, 32'h0000_0400);
    @(posedge clk); #1;
    chk(pc == 32'h0000_3000, "R2 stall hold jal", pc, 32'h0000_3000);
    instr = {6'h04, 5'd1, 5'd2, 16'h0008}; rs_val = 32'h9; rt_val = 32'h9;
    @(posedge clk); #1;
    chk(pc == 32'h0000_3000, "R2 stall hold beq", pc, 32'h0000_3000);
    instr = jr_word(); rs_val = 32'h0000_5001; #2;
    chk(jr_misalign, "R9 flag under stall", {31'h0, jr_misalign}, 32'h1);
    @(posedge clk); #1;
    chk(pc == 32'h0000_3000, "R2 stall hold jr", pc, 32'h0000_3000);
    stall = 1'b0; instr = {6'h03, 26'h0000100}; #2;
    chk(link_we, "R7 link after release", {31'h0, link_we}, 32'h1);
    @(posedge clk); #1;
    chk(pc == 32'h0000_0400, "R10 release takes jal", pc, 32'h0000_0400);

    load_pc(32'h0000_0100);
    rst = 1'b1; instr = {6'h02, 26'h0000800};
    @(posedge clk); #1;
    chk(pc == 32'h0, "R1 reset over jump", pc, 32'h0);
    rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule